// File: doc/BRIEF.md
# Masked Packed Half-Precision to Signed 16-bit Integer Converter

This block turns a packed vector of IEEE half-precision values into a packed vector of signed 16-bit integers. One vector goes in per accepted cycle. The active width is 128, 256 or 512 bits, which gives 8, 16 or 32 lanes. A per-lane enable mask chooses which lanes take the converted value. The other lanes either become zero or keep the matching lane of the old destination vector that the caller supplies. Lanes above the active width are always zero.

A source flagged as coming from memory can be broadcast: lane 0 of the source then feeds every lane. Rounding normally follows a global two-bit mode. A per-operation override replaces it, but only for a register source at full 512-bit width with the broadcast/override bit set. Any value that has no signed 16-bit form after rounding gives the indefinite pattern 0x8000. Two flags are formed by OR over the lanes that actually took a converted value: invalid, and inexact (precision loss). Results and flags are registered and appear one cycle after the input. A two-state machine produces the output valid:
- ST_IDLE goes to ST_DONE when `in_valid` is high.
- ST_DONE stays in ST_DONE while `in_valid` stays high.
- ST_DONE goes back to ST_IDLE when `in_valid` is low.

Top module: `hvec_to_i16`

## Requirements
- R1: `vlen` selects the active width: 00 = 128 bits (8 lanes), 01 = 256 bits (16 lanes), 10 or 11 = 512 bits (32 lanes). Destination bits above the active width are zero, whatever the mask and the old destination hold.
- R2: A written lane holds its source element converted to a signed 16-bit integer. The input layout is sign bit 15, exponent bits 14:10 with bias 15, and fraction bits 9:0. Subnormals are valid inputs of magnitude below one. Mode 00 rounds to nearest with ties to even.
- R3: With `mask_en`=1 and `zero_mode`=0, an active lane whose `mask` bit is 0 outputs the matching 16 bits of `old_dst`.
- R4: With `mask_en`=1 and `zero_mode`=1, an active lane whose `mask` bit is 0 outputs zero.
- R5: With `mask_en`=0, every active lane is written with its converted value, and the `mask` input has no effect.
- R6: When `src_is_mem`=1 and `bcast`=1, every lane converts source bits 15:0. With `src_is_mem`=0, `bcast` never broadcasts.
- R7: Rounding mode 01 rounds toward negative infinity, 10 toward positive infinity, and 11 toward zero.
- R8: The mode comes from `emb_rc` only when `src_is_mem`=0, the width is 512 and `bcast`=1. In every other case it comes from `glob_rc`.
- R9: A NaN, an infinity, or a rounded value outside [-32768, 32767] in a written lane gives 0x8000 and sets `flag_invalid`.
- R10: A written lane whose value is finite, in range and not an exact integer sets `flag_inexact`.
- R11: Lanes that are masked off, and lanes above the active width, never set either flag.
- R12: `out_valid`, `dst` and the flags update one clock after a cycle with `in_valid`=1. Without `in_valid`, `dst` and the flags hold their values and `out_valid` falls. Reset clears `dst`, the flags and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the operands this cycle |
| vlen | input | 2 | Active width: 00 = 128, 01 = 256, 1x = 512 |
| src | input | 512 | Packed half-precision source, lane j at bits 16j+15:16j |
| old_dst | input | 512 | Previous destination, used for merge lanes |
| mask | input | 32 | Per-lane write enable, bit j controls lane j |
| mask_en | input | 1 | 1 = apply the mask, 0 = write every active lane |
| zero_mode | input | 1 | 1 = masked lanes become zero, 0 = masked lanes keep old_dst |
| src_is_mem | input | 1 | Source is flagged as a memory operand |
| bcast | input | 1 | Broadcast (memory source) or rounding override (register source) |
| emb_rc | input | 2 | Per-operation rounding mode |
| glob_rc | input | 2 | Global rounding mode |
| out_valid | output | 1 | Registered result is valid this cycle |
| dst | output | 512 | Packed signed 16-bit results |
| flag_invalid | output | 1 | Some written lane was invalid |
| flag_inexact | output | 1 | Some written lane was rounded |

## Verification
All results, both flags and `out_valid` are due exactly one clock after the edge that sees `in_valid`=1. The bench therefore raises `in_valid` for one cycle on a falling edge and compares `dst` and the flags on the next falling edge. At that point exactly one register stage has loaded. The hold behaviour is checked several cycles later, after the inputs have changed with `in_valid` low: the outputs must still show the last result, and `out_valid` must have dropped.

// File: rtl/hcv_pkg.sv
package hcv_pkg;
    parameter int ELEM_W = 16;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } cvt_state_t;

    localparam logic [ELEM_W-1:0] INT_INDEF = 16'h8000;
endpackage

// File: rtl/hcv_rm_sel.sv
module hcv_rm_sel
    import hcv_pkg::*;
(
    input  logic       src_is_mem,
    input  logic       full_width,
    input  logic       bcast,
    input  logic [1:0] emb_rc,
    input  logic [1:0] glob_rc,
    output rmode_t     rm,
    output logic       override
);
    always_comb begin
        override = !src_is_mem && full_width && bcast;
        rm       = override ? rmode_t'(emb_rc) : rmode_t'(glob_rc);
    end

    // R8: without the override the global field must be in force
    always_comb begin
        a_r8_global_default: assert (override || rm == rmode_t'(glob_rc));
    end
endmodule

// File: rtl/hcv_lane.sv
module hcv_lane
    import hcv_pkg::*;
(
    input  logic [ELEM_W-1:0] h,
    input  rmode_t            rm,
    output logic [ELEM_W-1:0] res,
    output logic              invalid,
    output logic              inexact
);
    logic        sgn;
    logic [4:0]  ex;
    logic [4:0]  ex_eff;
    logic [10:0] sig;
    logic [39:0] fixed;
    logic [15:0] ipart;
    logic [23:0] fpart;
    logic        guard;
    logic        sticky;
    logic        rnd_up;
    logic [16:0] mag;
    logic        nan_inf;
    logic        over;

    always_comb begin
        sgn     = h[15];
        ex      = h[14:10];
        sig     = (ex == 5'd0) ? {1'b0, h[9:0]} : {1'b1, h[9:0]};
        ex_eff  = (ex == 5'd0) ? 5'd1 : ex;
        // value scaled by 2^24: integer part above bit 24
        fixed   = {29'd0, sig} << (ex_eff - 5'd1);
        ipart   = fixed[39:24];
        fpart   = fixed[23:0];
        guard   = fpart[23];
        sticky  = |fpart[22:0];
        unique case (rm)
            RM_NEAR: rnd_up = guard && (sticky || ipart[0]);
            RM_DOWN: rnd_up = sgn && (|fpart);
            RM_UP:   rnd_up = !sgn && (|fpart);
            RM_ZERO: rnd_up = 1'b0;
        endcase
        mag     = {1'b0, ipart} + {16'd0, rnd_up};
        nan_inf = (ex == 5'd31);
        over    = sgn ? (mag > 17'd32768) : (mag > 17'd32767);
        invalid = nan_inf || over;
        inexact = !invalid && (|fpart);
        if (invalid)
            res = INT_INDEF;
        else if (sgn)
            res = ~mag[15:0] + 16'd1;
        else
            res = mag[15:0];
    end

    // R9: special inputs always give the indefinite pattern
    always_comb begin
        a_r9_special_indef: assert (!nan_inf || (invalid && res == INT_INDEF));
    end
endmodule

// File: rtl/hvec_to_i16.sv
module hvec_to_i16
    import hcv_pkg::*;
#(
    parameter int MAX_W = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       vlen,
    input  logic [MAX_W-1:0] src,
    input  logic [MAX_W-1:0] old_dst,
    input  logic [MAX_W/ELEM_W-1:0] mask,
    input  logic             mask_en,
    input  logic             zero_mode,
    input  logic             src_is_mem,
    input  logic             bcast,
    input  logic [1:0]       emb_rc,
    input  logic [1:0]       glob_rc,
    output logic             out_valid,
    output logic [MAX_W-1:0] dst,
    output logic             flag_invalid,
    output logic             flag_inexact
);
    localparam int LANES = MAX_W / ELEM_W;
    localparam int LCW   = $clog2(LANES) + 1;

    cvt_state_t       state_q, state_d;
    logic [LCW-1:0]   n_lanes;
    logic             full_width;
    logic             do_bcast;
    rmode_t           rm;
    logic             rm_override;
    logic [MAX_W-1:0] next_dst;
    logic [LANES-1:0] wr_v, inv_v, inx_v;

    always_comb begin
        unique case (vlen)
            2'b00:   n_lanes = LCW'(LANES / 4);
            2'b01:   n_lanes = LCW'(LANES / 2);
            default: n_lanes = LCW'(LANES);
        endcase
        full_width = vlen[1];
        do_bcast   = src_is_mem && bcast;
    end

    hcv_rm_sel u_rm (
        .src_is_mem (src_is_mem),
        .full_width (full_width),
        .bcast      (bcast),
        .emb_rc     (emb_rc),
        .glob_rc    (glob_rc),
        .rm         (rm),
        .override   (rm_override)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [ELEM_W-1:0] elem, conv;
        logic              l_inv, l_inx, active;

        assign elem   = do_bcast ? src[ELEM_W-1:0] : src[j*ELEM_W +: ELEM_W];
        assign active = (LCW'(j) < n_lanes);
        assign wr_v[j] = active && (!mask_en || mask[j]);

        hcv_lane u_cvt (
            .h       (elem),
            .rm      (rm),
            .res     (conv),
            .invalid (l_inv),
            .inexact (l_inx)
        );

        assign inv_v[j] = wr_v[j] && l_inv;
        assign inx_v[j] = wr_v[j] && l_inx;
        assign next_dst[j*ELEM_W +: ELEM_W] =
            !active   ? '0 :
            wr_v[j]   ? conv :
            zero_mode ? '0 : old_dst[j*ELEM_W +: ELEM_W];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_DONE;
            ST_DONE: if (!in_valid) state_d = ST_IDLE;
        endcase
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst          <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else if (in_valid) begin
            dst          <= next_dst;
            flag_invalid <= |inv_v;
            flag_inexact <= |inx_v;
        end
    end

    assign out_valid = (state_q == ST_DONE);

    a_r12_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dst) && $stable(flag_invalid) && !out_valid));

    a_r1_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen == 2'b00) |=> (dst[MAX_W-1:MAX_W/4] == '0));

    a_r11_no_flag_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && mask == '0) |=> (!flag_invalid && !flag_inexact));
endmodule

// File: tb/sim_hvec_to_i16.sv
module sim_hvec_to_i16;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   vlen = 2'b10;
    logic [511:0] src = '0;
    logic [511:0] old_dst = '0;
    logic [31:0]  mask = '0;
    logic         mask_en = 1'b0;
    logic         zero_mode = 1'b0;
    logic         src_is_mem = 1'b0;
    logic         bcast = 1'b0;
    logic [1:0]   emb_rc = 2'b00;
    logic [1:0]   glob_rc = 2'b00;
    logic         out_valid;
    logic [511:0] dst;
    logic         flag_invalid, flag_inexact;

    int checks = 0;
    int errors = 0;
    logic [511:0] exp_dst;
    logic         exp_inv, exp_inx;

    always #4 clk = ~clk;

    hvec_to_i16 u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vlen(vlen),
        .src(src), .old_dst(old_dst), .mask(mask), .mask_en(mask_en),
        .zero_mode(zero_mode), .src_is_mem(src_is_mem), .bcast(bcast),
        .emb_rc(emb_rc), .glob_rc(glob_rc), .out_valid(out_valid),
        .dst(dst), .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    function automatic void ref_conv(input logic [15:0] h, input logic [1:0] rmode,
                                     output logic [15:0] r, output logic inv,
                                     output logic inx);
        real v, fl, diff, rr;
        int  ex, mi, ir;
        inv = 1'b0; inx = 1'b0; r = 16'h0;
        ex = int'(h[14:10]);
        if (ex == 31) begin
            inv = 1'b1; r = 16'h8000;
            return;
        end
        mi = (ex == 0) ? int'(h[9:0]) : 1024 + int'(h[9:0]);
        if (ex == 0) ex = 1;
        v = real'(mi);
        for (int k = ex; k < 25; k++) v = v / 2.0;
        for (int k = 25; k < ex; k++) v = v * 2.0;
        if (h[15]) v = -v;
        fl = $floor(v);
        diff = v - fl;
        case (rmode)
            2'b00: if (diff > 0.5) rr = fl + 1.0;
                   else if (diff < 0.5) rr = fl;
                   else rr = (($rtoi(fl) % 2) == 0) ? fl : fl + 1.0;
            2'b01: rr = fl;
            2'b10: rr = (diff > 0.0) ? fl + 1.0 : fl;
            default: rr = (v >= 0.0 || diff == 0.0) ? fl : fl + 1.0;
        endcase
        ir = $rtoi(rr);
        if (ir > 32767 || ir < -32768) begin
            inv = 1'b1; r = 16'h8000;
        end else begin
            r = 16'(ir);
            inx = (diff != 0.0);
        end
    endfunction

    task automatic compute_exp();
        int nl;
        logic [1:0] rmode;
        logic [15:0] e, r;
        logic li, lx;
        nl = (vlen == 2'b00) ? 8 : (vlen == 2'b01) ? 16 : 32;
        rmode = (!src_is_mem && vlen[1] && bcast) ? emb_rc : glob_rc;
        exp_dst = '0; exp_inv = 1'b0; exp_inx = 1'b0;
        for (int j = 0; j < nl; j++) begin
            if (!mask_en || mask[j]) begin
                e = (src_is_mem && bcast) ? src[15:0] : src[j*16 +: 16];
                ref_conv(e, rmode, r, li, lx);
                exp_dst[j*16 +: 16] = r;
                exp_inv |= li; exp_inx |= lx;
            end else if (!zero_mode) begin
                exp_dst[j*16 +: 16] = old_dst[j*16 +: 16];
            end
        end
    endtask

    task automatic chk_vec(string rq, logic [511:0] act, logic [511:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: dst actual=%h expected=%h", rq, act, expv);
        end
    endtask

    task automatic chk_bit(string rq, string what, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: %s actual=%0b expected=%0b", rq, what, act, expv);
        end
    endtask

    // drive one operation, result due one clock later
    task automatic run_op(string rq);
        compute_exp();
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk_bit("R12", "out_valid", out_valid, 1'b1);
        chk_vec(rq, dst, exp_dst);
        chk_bit(rq, "flag_invalid R9", flag_invalid, exp_inv);
        chk_bit(rq, "flag_inexact R10", flag_inexact, exp_inx);
    endtask

    task automatic set_ctl(logic [1:0] vl, logic me, logic zm, logic mem, logic bc,
                           logic [1:0] erc, logic [1:0] grc);
        vlen = vl; mask_en = me; zero_mode = zm; src_is_mem = mem; bcast = bc;
        emb_rc = erc; glob_rc = grc;
    endtask

    function automatic logic [15:0] rand_h();
        logic [15:0] h;
        h = 16'($urandom);
        if ($urandom_range(3) != 0) h[14:10] = 5'($urandom_range(29, 8));
        return h;
    endfunction

    task automatic fill_rand();
        for (int j = 0; j < 32; j++) src[j*16 +: 16] = rand_h();
        for (int j = 0; j < 16; j++) old_dst[j*32 +: 32] = $urandom;
        mask = $urandom;
    endtask

    task automatic fill_table(int which);
        logic [15:0] t [8];
        if (which == 0) begin
            t = '{16'h3800, 16'h3E00, 16'h4100, 16'hB800,
                  16'hBE00, 16'h0001, 16'h3C00, 16'hB555};
        end else begin
            t = '{16'h7E00, 16'h7C00, 16'hFC00, 16'h7800,
                  16'hF800, 16'h77FF, 16'hF801, 16'h3A00};
        end
        for (int j = 0; j < 32; j++) src[j*16 +: 16] = t[j % 8];
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk_vec("R12", dst, '0);
        chk_bit("R12", "out_valid", out_valid, 1'b0);
        chk_bit("R12", "flag_invalid", flag_invalid, 1'b0);

        // R2 nearest-even, halves and subnormal
        fill_table(0);
        set_ctl(2'b10, 0, 0, 0, 0, 2'b00, 2'b00);
        run_op("R2");
        // R7 directed modes
        set_ctl(2'b10, 0, 0, 0, 0, 2'b00, 2'b01); run_op("R7");
        set_ctl(2'b10, 0, 0, 0, 0, 2'b00, 2'b10); run_op("R7");
        set_ctl(2'b10, 0, 0, 0, 0, 2'b00, 2'b11); run_op("R7");
        // R9 specials and range edges
        fill_table(1);
        set_ctl(2'b10, 0, 0, 0, 0, 2'b00, 2'b00); run_op("R9");
        // R10 single inexact lane only
        src = '0; src[16*5 +: 16] = 16'h3E66;
        run_op("R10");
        // R3 merge
        fill_rand(); mask = 32'hA5A5_3C3C;
        set_ctl(2'b10, 1, 0, 0, 0, 2'b00, 2'b00); run_op("R3");
        // R4 zeroing
        set_ctl(2'b10, 1, 1, 0, 0, 2'b00, 2'b00); run_op("R4");
        // R5 mask ignored when disabled
        mask = '0;
        set_ctl(2'b10, 0, 1, 0, 0, 2'b00, 2'b00); run_op("R5");
        // R6 memory broadcast at 256
        fill_table(0); src[15:0] = 16'h4100;
        set_ctl(2'b01, 0, 0, 1, 1, 2'b10, 2'b00); run_op("R6");
        // R6 register with bcast at 256: no broadcast, global rounding (R8)
        set_ctl(2'b01, 0, 0, 0, 1, 2'b10, 2'b00); run_op("R6");
        // R8 override active: reg, 512, bcast
        fill_table(0);
        set_ctl(2'b10, 0, 0, 0, 1, 2'b10, 2'b00); run_op("R8");
        // R8 memory at 512 with bcast: global mode, broadcast
        src[15:0] = 16'h3E00;
        set_ctl(2'b10, 0, 0, 1, 1, 2'b10, 2'b00); run_op("R8");
        // R1 narrow width clears upper bits, code 11 acts as 512
        fill_rand(); old_dst = {16{32'hDEAD_BEEF}};
        set_ctl(2'b00, 1, 0, 0, 0, 2'b00, 2'b00); run_op("R1");
        set_ctl(2'b11, 1, 0, 0, 0, 2'b00, 2'b00); run_op("R1");
        // R11 masked and inactive lanes do not raise flags
        fill_table(1); mask = 32'h0;
        set_ctl(2'b10, 1, 0, 0, 0, 2'b00, 2'b00); run_op("R11");
        mask = 32'hFFFF_FF00; src[127:0] = {8{16'h3E66}};
        set_ctl(2'b00, 1, 1, 0, 0, 2'b00, 2'b00); run_op("R11");
        // R12 hold without in_valid
        fill_rand(); glob_rc = 2'b11;
        repeat (3) @(negedge clk);
        chk_vec("R12", dst, exp_dst);
        chk_bit("R12", "out_valid low", out_valid, 1'b0);
        chk_bit("R12", "flag_invalid held", flag_invalid, exp_inv);

        // random mix over R2, R3, R4, R7, R9
        for (int n = 0; n < 400; n++) begin
            fill_rand();
            set_ctl(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 2'($urandom), 2'($urandom));
            run_op("R2,R3,R4,R7");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule